// File: doc/BRIEF.md
# Clock-Rate Operating Mode Detector

This block sits on the receiving side of a one-bit oversampled audio link. It picks an operating mode from one thing only: how fast the incoming bit clock toggles. A free-running reference clock times a fixed measurement window. Rising edges of the synchronised bit clock are counted inside that window, and each window's count is sorted into a rate band. The four bands are Sleep, Low-Power, Standard and High-Performance. Counts that fall between bands are treated as a gap and do not move the mode.

A band has to be seen in two windows in a row before it is acted on. A separate idle timer catches a clock that has stopped altogether. A mode state machine applies its own settling delay to each kind of change: waking from Sleep, switching between two active modes, and entering Sleep.

The block drives four outputs:
- the current mode;
- a data-valid flag;
- a data-output enable;
- a pull-low control for the shared data line.

The pull-low control is used only while the block is not driving data and the channel strap is high. With the strap low, the line is left floating instead.

Top module: `clk_rate_mode_det`

## Requirements
- R1: After reset, `mode_o` is Sleep, and `data_valid_o` and `data_oe_o` are 0. The mode code is 0 = Sleep, 1 = Low-Power, 2 = Standard, 3 = High-Performance.
- R2: Rising bit-clock edges are counted in each window of WIN_CYCLES (240) reference cycles. With default parameters the bands are: 0..3 is Sleep, 8..12 is Low-Power, 20..36 is Standard and 50..64 is High-Performance.
- R3: A count that falls in a gap between bands (4..7, 13..19, 37..49, above 64) leaves the mode unchanged for as long as it lasts.
- R4: A band takes effect only when two consecutive windows report it. One window in a different band causes no mode change.
- R5: When waking from Sleep, `mode_o` stays Sleep and `data_valid_o` stays 0 for at least WAKE_DLY (400) cycles after the rate changes. The new mode and valid data appear within three windows plus WAKE_DLY plus 20 cycles.
- R6: A switch between two active modes does not complete before SWITCH_DLY (200) cycles. It completes within three windows plus SWITCH_DLY plus 20 cycles. `data_valid_o` stays 1 throughout the switch.
- R7: When the rate drops into the Sleep band, data stays valid for at least SLEEP_DLY (100) cycles. Sleep, with `data_valid_o` at 0, is reached within three windows plus SLEEP_DLY plus 20 cycles.
- R8: If no bit-clock edge arrives for IDLE_LIMIT (100) reference cycles, Sleep is entered SLEEP_DLY cycles later. This path does not wait for any window to complete.
- R9: `data_oe_o` follows `data_valid_o`. `data_valid_o` is 1 exactly when `mode_o` is not Sleep.
- R10: While data is not valid, `pull_low_o` equals `sel_i`. While data is valid, `pull_low_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Incoming bit clock, asynchronous to clk_i |
| sel_i | input | 1 | Channel strap; high selects pull-low while asleep |
| mode_o | output | 2 | Current mode: 0 Sleep, 1 Low-Power, 2 Standard, 3 High-Performance |
| data_valid_o | output | 1 | Output data may be used |
| data_oe_o | output | 1 | Enable for the data-line driver |
| pull_low_o | output | 1 | Actively pull the data line low |

## Verification
The hardest case to reach from the ports is a short burst at a different rate that must not cause a mode change. The burst can straddle a window boundary, so each half lands in a partial window with a mixed count. The bench runs a 240-cycle burst at the High-Performance rate while the block is in Standard mode. This burst is too short for two consecutive windows to both read High-Performance, so the mode must hold. The bench checks mode and valid on every cycle of a long observation span.

The same care covers the gap-rate tests and the stopped-clock test. For the stopped clock, the deadline for Sleep is set earlier than any two-window decision could arrive, so only the idle timer can explain a pass.

// File: rtl/rate_mode_pkg.sv
package rate_mode_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP = 2'd0,
      MODE_LOW   = 2'd1,
      MODE_STD   = 2'd2,
      MODE_HIGH  = 2'd3
   } op_mode_e;

   typedef enum logic [2:0] {
      BAND_SLEEP = 3'd0,
      BAND_LOW   = 3'd1,
      BAND_STD   = 3'd2,
      BAND_HIGH  = 3'd3,
      BAND_GAP   = 3'd4
   } rate_band_e;

   function automatic op_mode_e band_to_mode(rate_band_e b);
      case (b)
         BAND_LOW:  return MODE_LOW;
         BAND_STD:  return MODE_STD;
         BAND_HIGH: return MODE_HIGH;
         default:   return MODE_SLEEP;
      endcase
   endfunction

endpackage

// File: rtl/bclk_rate_meter.sv
module bclk_rate_meter #(
   parameter int WIN_CYCLES  = 240,
   parameter int SYNC_STAGES = 2,
   parameter bit BOTH_EDGES  = 1'b0,
   parameter int IDLE_LIMIT  = 100,
   parameter int CNT_W       = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bclk_i,
   output logic             win_done_o,
   output logic [CNT_W-1:0] edge_cnt_o,
   output logic             clk_lost_o
);

   localparam int WIN_W  = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
   localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   edge_w;
   logic [WIN_W-1:0]       win_q;
   logic [CNT_W-1:0]       acc_q;
   logic [CNT_W-1:0]       acc_nxt;
   logic                   win_end;
   logic [IDLE_W-1:0]      idle_q;

   // synchroniser chain for the asynchronous bit clock
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], bclk_i};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   generate
      if (BOTH_EDGES) begin : g_both_edges
         assign edge_w = sync_q[SYNC_STAGES-1] ^ last_q;
      end else begin : g_rise_edge
         assign edge_w = sync_q[SYNC_STAGES-1] & ~last_q;
      end
   endgenerate

   assign win_end = (win_q == WIN_W'(WIN_CYCLES - 1));
   assign acc_nxt = (edge_w && (acc_q != '1)) ? acc_q + 1'b1 : acc_q;

   // fixed-length measurement window
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         win_q      <= '0;
         acc_q      <= '0;
         edge_cnt_o <= '0;
         win_done_o <= 1'b0;
      end else if (win_end) begin
         win_q      <= '0;
         acc_q      <= '0;
         edge_cnt_o <= acc_nxt;
         win_done_o <= 1'b1;
      end else begin
         win_q      <= win_q + 1'b1;
         acc_q      <= acc_nxt;
         win_done_o <= 1'b0;
      end
   end

   // idle timer: flags a bit clock that has stopped toggling
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idle_q     <= '0;
         clk_lost_o <= 1'b0;
      end else if (edge_w) begin
         idle_q     <= '0;
         clk_lost_o <= 1'b0;
      end else if (idle_q != IDLE_W'(IDLE_LIMIT)) begin
         idle_q     <= idle_q + 1'b1;
         clk_lost_o <= (idle_q == IDLE_W'(IDLE_LIMIT - 1));
      end else begin
         clk_lost_o <= 1'b0;
      end
   end

endmodule

// File: rtl/rate_band_qualifier.sv
module rate_band_qualifier
   import rate_mode_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int SLEEP_MAX = 3,
   parameter int LOW_MIN   = 8,
   parameter int LOW_MAX   = 12,
   parameter int STD_MIN   = 20,
   parameter int STD_MAX   = 36,
   parameter int HIGH_MIN  = 50,
   parameter int HIGH_MAX  = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             win_done_i,
   input  logic [CNT_W-1:0] edge_cnt_i,
   input  logic             clk_lost_i,
   output logic             dec_valid_o,
   output rate_band_e       dec_band_o
);

   rate_band_e band_w;
   rate_band_e prev_q;

   // sort one window count into a band
   always_comb begin
      if (edge_cnt_i <= CNT_W'(SLEEP_MAX))
         band_w = BAND_SLEEP;
      else if (edge_cnt_i >= CNT_W'(LOW_MIN) && edge_cnt_i <= CNT_W'(LOW_MAX))
         band_w = BAND_LOW;
      else if (edge_cnt_i >= CNT_W'(STD_MIN) && edge_cnt_i <= CNT_W'(STD_MAX))
         band_w = BAND_STD;
      else if (edge_cnt_i >= CNT_W'(HIGH_MIN) && edge_cnt_i <= CNT_W'(HIGH_MAX))
         band_w = BAND_HIGH;
      else
         band_w = BAND_GAP;
   end

   // a decision needs two agreeing windows; a stopped clock decides at once
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q      <= BAND_GAP;
         dec_valid_o <= 1'b0;
         dec_band_o  <= BAND_SLEEP;
      end else if (clk_lost_i) begin
         prev_q      <= BAND_SLEEP;
         dec_valid_o <= 1'b1;
         dec_band_o  <= BAND_SLEEP;
      end else if (win_done_i) begin
         prev_q      <= band_w;
         dec_valid_o <= (band_w == prev_q) && (band_w != BAND_GAP);
         dec_band_o  <= band_w;
      end else begin
         dec_valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/op_mode_fsm.sv
module op_mode_fsm
   import rate_mode_pkg::*;
#(
   parameter int WAKE_DLY   = 400,
   parameter int SWITCH_DLY = 200,
   parameter int SLEEP_DLY  = 100,
   parameter int TMR_W      = 9
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       dec_valid_i,
   input  rate_band_e dec_band_i,
   output op_mode_e   mode_o,
   output logic       valid_o
);

   typedef enum logic [2:0] {
      ST_SLEEP, ST_WAKE, ST_ACTIVE, ST_SWITCH, ST_DOZE
   } fsm_st_e;

   fsm_st_e        st_q;
   op_mode_e       tgt_q;
   logic [TMR_W-1:0] tmr_q;
   op_mode_e       dec_mode;
   logic           dec_sleep;

   assign dec_mode  = band_to_mode(dec_band_i);
   assign dec_sleep = (dec_band_i == BAND_SLEEP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_SLEEP;
         tgt_q   <= MODE_SLEEP;
         tmr_q   <= '0;
         mode_o  <= MODE_SLEEP;
         valid_o <= 1'b0;
      end else begin
         unique case (st_q)
            ST_SLEEP: begin
               if (dec_valid_i && !dec_sleep) begin
                  tgt_q <= dec_mode;
                  tmr_q <= TMR_W'(WAKE_DLY - 1);
                  st_q  <= ST_WAKE;
               end
            end
            ST_WAKE: begin
               if (dec_valid_i && dec_sleep) begin
                  st_q <= ST_SLEEP;
               end else if (dec_valid_i && dec_mode != tgt_q) begin
                  tgt_q <= dec_mode;
                  tmr_q <= TMR_W'(WAKE_DLY - 1);
               end else if (tmr_q == '0) begin
                  mode_o  <= tgt_q;
                  valid_o <= 1'b1;
                  st_q    <= ST_ACTIVE;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_ACTIVE: begin
               if (dec_valid_i && dec_sleep) begin
                  tmr_q <= TMR_W'(SLEEP_DLY - 1);
                  st_q  <= ST_DOZE;
               end else if (dec_valid_i && dec_mode != mode_o) begin
                  tgt_q <= dec_mode;
                  tmr_q <= TMR_W'(SWITCH_DLY - 1);
                  st_q  <= ST_SWITCH;
               end
            end
            ST_SWITCH: begin
               if (dec_valid_i && dec_sleep) begin
                  tmr_q <= TMR_W'(SLEEP_DLY - 1);
                  st_q  <= ST_DOZE;
               end else if (dec_valid_i && dec_mode == mode_o) begin
                  st_q <= ST_ACTIVE;
               end else if (dec_valid_i && dec_mode != tgt_q) begin
                  tgt_q <= dec_mode;
                  tmr_q <= TMR_W'(SWITCH_DLY - 1);
               end else if (tmr_q == '0) begin
                  mode_o <= tgt_q;
                  st_q   <= ST_ACTIVE;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_DOZE: begin
               if (dec_valid_i && !dec_sleep && dec_mode == mode_o) begin
                  st_q <= ST_ACTIVE;
               end else if (dec_valid_i && !dec_sleep) begin
                  tgt_q <= dec_mode;
                  tmr_q <= TMR_W'(SWITCH_DLY - 1);
                  st_q  <= ST_SWITCH;
               end else if (tmr_q == '0) begin
                  mode_o  <= MODE_SLEEP;
                  valid_o <= 1'b0;
                  st_q    <= ST_SLEEP;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            default: st_q <= ST_SLEEP;
         endcase
      end
   end

endmodule

// File: rtl/clk_rate_mode_det.sv
module clk_rate_mode_det
   import rate_mode_pkg::*;
#(
   parameter int WIN_CYCLES  = 240,
   parameter int SYNC_STAGES = 2,
   parameter bit BOTH_EDGES  = 1'b0,
   parameter int IDLE_LIMIT  = 100,
   parameter int SLEEP_MAX   = 3,
   parameter int LOW_MIN     = 8,
   parameter int LOW_MAX     = 12,
   parameter int STD_MIN     = 20,
   parameter int STD_MAX     = 36,
   parameter int HIGH_MIN    = 50,
   parameter int HIGH_MAX    = 64,
   parameter int WAKE_DLY    = 400,
   parameter int SWITCH_DLY  = 200,
   parameter int SLEEP_DLY   = 100
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       bclk_i,
   input  logic       sel_i,
   output logic [1:0] mode_o,
   output logic       data_valid_o,
   output logic       data_oe_o,
   output logic       pull_low_o
);

   localparam int EDGE_MAX = BOTH_EDGES ? WIN_CYCLES : (WIN_CYCLES + 1) / 2;
   localparam int CNT_W    = $clog2(EDGE_MAX + 1);
   localparam int DLY_MAX  = (WAKE_DLY > SWITCH_DLY)
                             ? ((WAKE_DLY > SLEEP_DLY) ? WAKE_DLY : SLEEP_DLY)
                             : ((SWITCH_DLY > SLEEP_DLY) ? SWITCH_DLY : SLEEP_DLY);
   localparam int TMR_W    = $clog2(DLY_MAX + 1);

   // elaboration-time parameter checks
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (!(SLEEP_MAX < LOW_MIN && LOW_MIN <= LOW_MAX && LOW_MAX < STD_MIN &&
            STD_MIN <= STD_MAX && STD_MAX < HIGH_MIN && HIGH_MIN <= HIGH_MAX)) begin : g_bad_bands
         $error("rate bands must be ordered and disjoint");
      end
      if (HIGH_MAX > EDGE_MAX) begin : g_bad_top
         $error("HIGH_MAX exceeds the largest countable value");
      end
      if (IDLE_LIMIT < 2 || WAKE_DLY < 1 || SWITCH_DLY < 1 || SLEEP_DLY < 1) begin : g_bad_dly
         $error("timer parameters must be positive");
      end
   endgenerate

   logic             win_done;
   logic [CNT_W-1:0] edge_cnt;
   logic             clk_lost;
   logic             dec_valid;
   rate_band_e       dec_band;
   op_mode_e         mode_w;
   logic             valid_w;

   bclk_rate_meter #(
      .WIN_CYCLES (WIN_CYCLES),
      .SYNC_STAGES(SYNC_STAGES),
      .BOTH_EDGES (BOTH_EDGES),
      .IDLE_LIMIT (IDLE_LIMIT),
      .CNT_W      (CNT_W)
   ) i_meter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .bclk_i    (bclk_i),
      .win_done_o(win_done),
      .edge_cnt_o(edge_cnt),
      .clk_lost_o(clk_lost)
   );

   rate_band_qualifier #(
      .CNT_W    (CNT_W),
      .SLEEP_MAX(SLEEP_MAX),
      .LOW_MIN  (LOW_MIN),
      .LOW_MAX  (LOW_MAX),
      .STD_MIN  (STD_MIN),
      .STD_MAX  (STD_MAX),
      .HIGH_MIN (HIGH_MIN),
      .HIGH_MAX (HIGH_MAX)
   ) i_qual (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .win_done_i (win_done),
      .edge_cnt_i (edge_cnt),
      .clk_lost_i (clk_lost),
      .dec_valid_o(dec_valid),
      .dec_band_o (dec_band)
   );

   op_mode_fsm #(
      .WAKE_DLY  (WAKE_DLY),
      .SWITCH_DLY(SWITCH_DLY),
      .SLEEP_DLY (SLEEP_DLY),
      .TMR_W     (TMR_W)
   ) i_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dec_valid_i(dec_valid),
      .dec_band_i (dec_band),
      .mode_o     (mode_w),
      .valid_o    (valid_w)
   );

   assign mode_o       = mode_w;
   assign data_valid_o = valid_w;
   assign data_oe_o    = valid_w;
   assign pull_low_o   = sel_i & ~valid_w;

endmodule

// File: rtl/clk_rate_mode_det_chk.sv
module clk_rate_mode_det_chk #(
   parameter int WAKE_DLY   = 400,
   parameter int SWITCH_DLY = 200,
   parameter int SLEEP_DLY  = 100
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] mode_o,
   input logic       data_valid_o
);

   localparam int RUN_MAX = (WAKE_DLY > SWITCH_DLY)
                            ? ((WAKE_DLY > SLEEP_DLY) ? WAKE_DLY : SLEEP_DLY)
                            : ((SWITCH_DLY > SLEEP_DLY) ? SWITCH_DLY : SLEEP_DLY);
   localparam int RUN_W   = $clog2(RUN_MAX + 2);

   logic [RUN_W-1:0] low_run;
   logic [RUN_W-1:0] stable_run;
   logic [1:0]       mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         low_run    <= '0;
         stable_run <= '0;
         mode_q     <= 2'd0;
      end else begin
         mode_q <= mode_o;
         if (data_valid_o)
            low_run <= '0;
         else if (low_run != RUN_W'(RUN_MAX + 1))
            low_run <= low_run + 1'b1;
         if (mode_o != mode_q)
            stable_run <= '0;
         else if (stable_run != RUN_W'(RUN_MAX + 1))
            stable_run <= stable_run + 1'b1;
      end
   end

   AST_VALID_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_valid_o == (mode_o != 2'd0)); // R9

   AST_WAKE_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(data_valid_o) |-> (int'(low_run) >= WAKE_DLY - 2)); // R5

   AST_SWITCH_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o != mode_q && mode_q != 2'd0 && mode_o != 2'd0) |->
      (int'(stable_run) >= SWITCH_DLY - 2)); // R6

   AST_SLEEP_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(data_valid_o) |-> (int'(stable_run) >= SLEEP_DLY - 2)); // R7

endmodule

bind clk_rate_mode_det clk_rate_mode_det_chk #(
   .WAKE_DLY  (WAKE_DLY),
   .SWITCH_DLY(SWITCH_DLY),
   .SLEEP_DLY (SLEEP_DLY)
) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .mode_o      (mode_o),
   .data_valid_o(data_valid_o)
);

// File: tb/test_clk_rate_mode_det.sv
module test_clk_rate_mode_det;

   localparam int WIN = 240;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b0;
   logic       sel = 1'b1;
   logic [1:0] mode;
   logic       valid;
   logic       oe;
   logic       pull;

   int n_chk  = 0;
   int n_fail = 0;
   int half   = 0;
   int hcnt   = 0;

   always #2 clk = ~clk;

   // bit-clock source: toggles every 'half' reference cycles, stops at 0
   always @(negedge clk) begin
      if (half == 0) hcnt <= 0;
      else if (hcnt >= half - 1) begin
         hcnt <= 0;
         bclk <= ~bclk;
      end else hcnt <= hcnt + 1;
   end

   clk_rate_mode_det i_clk_rate_mode_det (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bclk_i      (bclk),
      .sel_i       (sel),
      .mode_o      (mode),
      .data_valid_o(valid),
      .data_oe_o   (oe),
      .pull_low_o  (pull)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // watch valid (and optionally mode) on every cycle for n cycles
   task automatic watch(input int n, input int exp_mode, input string req);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         cyc(1);
         if (!valid || (exp_mode >= 0 && int'(mode) != exp_mode)) bad++;
      end
      chk(bad == 0, req, "cycles with lost valid or wrong mode", bad, 0);
   endtask

   task automatic t_reset;
      chk(mode == 2'd0, "R1", "mode after reset", mode, 0);
      chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
      chk(oe == 1'b0, "R1", "oe after reset", oe, 0);
      chk(pull == 1'b1, "R10", "pull-low asleep with strap high", pull, 1);
      sel = 1'b0;
      #1;
      chk(pull == 1'b0, "R10", "pull-low asleep with strap low", pull, 0);
      sel = 1'b1;
      #1;
   endtask

   task automatic t_wake_high;
      half = 2;
      cyc(400);
      chk(valid == 1'b0, "R5", "valid before wake delay", valid, 0);
      chk(mode == 2'd0, "R5", "mode during wake", mode, 0);
      chk(pull == 1'b1, "R10", "pull-low while waking", pull, 1);
      cyc(3 * WIN + 20);
      chk(valid == 1'b1, "R5", "valid after wake", valid, 1);
      chk(mode == 2'd3, "R2", "high-rate band mode", mode, 3);
      chk(oe == 1'b1, "R9", "oe follows valid", oe, 1);
      chk(pull == 1'b0, "R10", "no pull-low while valid", pull, 0);
   endtask

   task automatic t_switch(input int new_half, input int old_mode,
                           input int new_mode, input string what);
      half = new_half;
      watch(200, old_mode, "R6");
      chk(int'(mode) == old_mode, "R6", {what, " not before switch delay"}, mode, old_mode);
      watch(3 * WIN + 20, -1, "R6");
      chk(int'(mode) == new_mode, "R6", {what, " completed"}, mode, new_mode);
   endtask

   task automatic t_glitch;
      half = 2;
      cyc(WIN);
      half = 4;
      watch(1000, 2, "R4");
      chk(mode == 2'd2, "R4", "mode after one-window burst", mode, 2);
   endtask

   task automatic t_gap;
      half = 8;
      watch(1200, 2, "R3");
      half = 3;
      watch(1200, 2, "R3");
      chk(mode == 2'd2, "R3", "mode after gap rates", mode, 2);
   endtask

   task automatic t_sleep_slow;
      half = 45;
      cyc(100);
      chk(valid == 1'b1, "R7", "valid held during sleep entry", valid, 1);
      cyc(3 * WIN + 20);
      chk(mode == 2'd0, "R7", "mode after slow rate", mode, 0);
      chk(valid == 1'b0, "R7", "valid in sleep", valid, 0);
      chk(oe == 1'b0, "R9", "oe in sleep", oe, 0);
      chk(pull == 1'b1, "R10", "pull-low asleep strap high", pull, 1);
   endtask

   task automatic t_wake_low_strap_low;
      sel = 1'b0;
      half = 12;
      cyc(WAKE_TOTAL());
      chk(mode == 2'd1, "R2", "low-rate band mode", mode, 1);
      chk(valid == 1'b1, "R5", "valid after low wake", valid, 1);
      chk(pull == 1'b0, "R10", "no pull-low strap low", pull, 0);
   endtask

   function automatic int WAKE_TOTAL();
      return 400 + 3 * WIN + 20;
   endfunction

   task automatic t_clk_stop;
      half = 0;
      cyc(60);
      chk(valid == 1'b1, "R8", "valid shortly after stop", valid, 1);
      cyc(170);
      chk(mode == 2'd0, "R8", "mode after clock loss", mode, 0);
      chk(oe == 1'b0, "R8", "oe after clock loss", oe, 0);
      chk(pull == 1'b0, "R10", "floating asleep strap low", pull, 0);
   endtask

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_wake_high();
      t_switch(4, 3, 2, "high to standard");
      t_glitch();
      t_gap();
      t_switch(12, 2, 1, "standard to low");
      t_switch(2, 1, 3, "low to high");
      t_sleep_slow();
      t_wake_low_strap_low();
      t_clk_stop();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule